// File: doc/BRIEF.md
# Sound Processor Banked Bus Window

This block decodes the 16-bit address space of an 8-bit sound processor and steers each access to its target. The low quarter of the space goes to an 8 KB local RAM, mirrored. The next eighth goes to four sound-chip ports. Writes to a small area at the start of the following eighth load a bank register one bit at a time. A 256-byte area at the top of that eighth reaches the video port on the main bus. The upper half of the space is a 32 KB window into the main bus, positioned by the bank register.

Local targets answer in the same cycle as the request. Main-bus targets go through a 16-bit master port that has a byte-lane mask. The request is registered and held until the bus acknowledges it, and the processor sees ready in the cycle of the acknowledge. Byte accesses are placed on a lane by address parity. An even address uses the upper byte of the 16-bit word and an odd address uses the lower byte.

Top module: `sound_bus_window`

## Requirements
- R1: Addresses 0x0000–0x3FFF reach local RAM at ram_addr = cpu_addr[12:0]. A read returns ram_rdata and a write pulses ram_we with the data. Both complete in the request cycle.
- R2: Addresses 0x4000–0x5FFF reach the sound chip. A write pulses snd_wr with snd_port = cpu_addr[1:0] and the data. A read returns snd_status whatever the port. Both complete in the request cycle.
- R3: A write to 0x6000–0x60FF shifts the 9-bit bank register right by one and places cpu_wdata[0] in bit 8. A read there returns 0xFF and leaves the bank unchanged.
- R4: Reset clears the bank register, so the first window access after reset uses main-bus address bits 23:15 equal to zero.
- R5: Addresses 0x7F00–0x7FFF go to main-bus address 0xC00000 | (cpu_addr & 0x7E).
- R6: Addresses 0x8000–0xFFFF go to main-bus address {bank, cpu_addr[14:1], 0}.
- R7: A main-bus read returns mb_rdata[15:8] for an even cpu_addr and mb_rdata[7:0] for an odd one.
- R8: A main-bus write drives the byte on both halves of mb_wdata. mb_mask is 0xFF00 for an even cpu_addr and 0x00FF for an odd one.
- R9: Addresses 0x6100–0x7EFF complete in the request cycle. They read 0xFF, and a write there drives no RAM, sound-chip or main-bus strobe and leaves the bank unchanged.
- R10: mb_req and its address, data, mask and direction stay unchanged until mb_ack. cpu_ready for a main-bus access is raised exactly in the mb_ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| ram_addr | output | 13 | Local RAM address |
| ram_we | output | 1 | Local RAM write strobe |
| ram_wdata | output | 8 | Local RAM write byte |
| ram_rdata | input | 8 | Local RAM asynchronous read byte |
| snd_wr | output | 1 | Sound-chip write strobe |
| snd_port | output | 2 | Sound-chip port select |
| snd_wdata | output | 8 | Sound-chip write byte |
| snd_status | input | 8 | Sound-chip status byte |
| mb_req | output | 1 | Main-bus request, held until mb_ack |
| mb_we | output | 1 | Main-bus write |
| mb_addr | output | 24 | Main-bus byte address (even) |
| mb_wdata | output | 16 | Main-bus write word |
| mb_mask | output | 16 | Main-bus byte-lane mask |
| mb_rdata | input | 16 | Main-bus read word |
| mb_ack | input | 1 | Main-bus completion |

## Verification
The bank register is the only internal state that lasts from one access to the next. A fault in it shows only at the next access to the upper window, in mb_addr bits 23:15. For that reason the bench puts a window read after each group of bank writes and after each sweep of unmapped addresses, so that a wrong shift or a stray update is seen within one access. A fault in the wait state shows as a ready that comes too early or too late, or as a request attribute that changes. The bench catches it by counting cycles to ready against a bus model with a fixed latency.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    typedef enum logic [2:0] {
        RG_RAM,
        RG_SND,
        RG_BANK,
        RG_HOLE,
        RG_VID,
        RG_WIN
    } region_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } state_e;

    localparam logic [15:0] BANK_LIMIT = 16'h6100;
    localparam logic [15:0] VID_START  = 16'h7F00;
    localparam logic [7:0]  OPEN_BYTE  = 8'hFF;

    typedef struct packed {
        logic [15:0] wdata;
        logic [15:0] mask;
    } lane_wr_t;

    function automatic logic goes_to_bus(region_e r);
        return (r == RG_VID) || (r == RG_WIN);
    endfunction

endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
    import sbw_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);
    always_comb begin
        case (addr[15:13])
            3'd0, 3'd1: region = RG_RAM;
            3'd2:       region = RG_SND;
            3'd3: begin
                if (addr < BANK_LIMIT)      region = RG_BANK;
                else if (addr >= VID_START) region = RG_VID;
                else                        region = RG_HOLE;
            end
            default:    region = RG_WIN;
        endcase
    end
endmodule

// File: rtl/sbw_bank.sv
module sbw_bank #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (shift_en)
            bank_q <= {bit_in, bank_q[W-1:1]};
    end
endmodule

// File: rtl/sbw_lanes.sv
module sbw_lanes
    import sbw_pkg::*;
(
    input  logic        odd,
    input  logic [7:0]  wbyte,
    input  logic [15:0] rword,
    output lane_wr_t    wr,
    output logic [7:0]  rbyte
);
    for (genvar i = 0; i < 2; i++) begin : g_lane
        assign wr.wdata[i*8 +: 8] = wbyte;
        assign wr.mask[i*8 +: 8]  = {8{(i == 0) ? odd : ~odd}};
    end

    assign rbyte = odd ? rword[7:0] : rword[15:8];
endmodule

// File: rtl/sound_bus_window.sv
module sound_bus_window
    import sbw_pkg::*;
#(
    parameter int              MB_AW    = 24,
    parameter int              RAM_AW   = 13,
    parameter logic [MB_AW-1:0] VID_BASE = 24'hC00000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              snd_wr,
    output logic [1:0]        snd_port,
    output logic [7:0]        snd_wdata,
    input  logic [7:0]        snd_status,
    output logic              mb_req,
    output logic              mb_we,
    output logic [MB_AW-1:0]  mb_addr,
    output logic [15:0]       mb_wdata,
    output logic [15:0]       mb_mask,
    input  logic [15:0]       mb_rdata,
    input  logic              mb_ack
);
    localparam int BANK_W = MB_AW - 15;
    localparam int VID_PAD = MB_AW - 7;

    region_e           region;
    state_e            state_q;
    logic [BANK_W-1:0] bank_q;
    logic              take;
    logic              bank_shift;
    logic [MB_AW-1:0]  tgt_addr;
    lane_wr_t          lane_wr;
    logic [7:0]        lane_rbyte;
    logic              odd_q;
    lane_wr_t          wr_q;
    logic [MB_AW-1:0]  addr_q;
    logic              we_q;

    sbw_decode u_decode (
        .addr   (cpu_addr),
        .region (region)
    );

    sbw_bank #(.W(BANK_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bank_shift),
        .bit_in   (cpu_wdata[0]),
        .bank_q   (bank_q)
    );

    sbw_lanes u_lanes (
        .odd   (state_q == ST_WAIT ? odd_q : cpu_addr[0]),
        .wbyte (cpu_wdata),
        .rword (mb_rdata),
        .wr    (lane_wr),
        .rbyte (lane_rbyte)
    );

    assign take       = (state_q == ST_IDLE) && cpu_req;
    assign ram_addr   = cpu_addr[RAM_AW-1:0];
    assign ram_wdata  = cpu_wdata;
    assign ram_we     = take && cpu_we && (region == RG_RAM);
    assign snd_port   = cpu_addr[1:0];
    assign snd_wdata  = cpu_wdata;
    assign snd_wr     = take && cpu_we && (region == RG_SND);
    assign bank_shift = take && cpu_we && (region == RG_BANK);

    always_comb begin
        if (region == RG_VID)
            tgt_addr = VID_BASE | {{VID_PAD{1'b0}}, cpu_addr[6:1], 1'b0};
        else
            tgt_addr = {bank_q, cpu_addr[14:1], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= '0;
            we_q    <= 1'b0;
            odd_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take && goes_to_bus(region)) begin
                        state_q <= ST_WAIT;
                        addr_q  <= tgt_addr;
                        wr_q    <= lane_wr;
                        we_q    <= cpu_we;
                        odd_q   <= cpu_addr[0];
                    end
                end
                default: begin
                    if (mb_ack)
                        state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign mb_req   = (state_q == ST_WAIT);
    assign mb_we    = we_q;
    assign mb_addr  = addr_q;
    assign mb_wdata = wr_q.wdata;
    assign mb_mask  = wr_q.mask;

    always_comb begin
        if (state_q == ST_WAIT) begin
            cpu_ready = mb_ack;
            cpu_rdata = lane_rbyte;
        end else begin
            cpu_ready = cpu_req && !goes_to_bus(region);
            case (region)
                RG_RAM:  cpu_rdata = ram_rdata;
                RG_SND:  cpu_rdata = snd_status;
                default: cpu_rdata = OPEN_BYTE;
            endcase
        end
    end
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
    parameter int MB_AW  = 24,
    parameter int RAM_AW = 13,
    parameter int BANK_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_ready,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              snd_wr,
    input logic              mb_req,
    input logic              mb_ack,
    input logic              mb_we,
    input logic [MB_AW-1:0]  mb_addr,
    input logic [15:0]       mb_wdata,
    input logic [15:0]       mb_mask,
    input logic [BANK_W-1:0] bank_q
);
    logic bank_hit;
    assign bank_hit = cpu_req && cpu_we && !mb_req &&
                      (cpu_addr[15:13] == 3'd3) && (cpu_addr < 16'h6100);

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mb_req && !mb_ack) |=> (mb_req && $stable(mb_addr) && $stable(mb_mask)
                                 && $stable(mb_wdata) && $stable(mb_we)));

    a_r10_ready_with_ack: assert property (@(posedge clk) disable iff (rst)
        mb_req |-> (cpu_ready == mb_ack));

    a_r8_lane_shape: assert property (@(posedge clk) disable iff (rst)
        (mb_req && mb_we) |-> ((mb_wdata[15:8] == mb_wdata[7:0]) &&
                               (mb_mask == 16'h00FF || mb_mask == 16'hFF00)));

    a_r9_hole_quiet: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !mb_req && cpu_addr >= 16'h6100 && cpu_addr < 16'h7F00)
        |-> (cpu_ready && !ram_we && !snd_wr));

    a_r1_ram_window: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_addr[15:14] == 2'b00 && ram_addr == cpu_addr[RAM_AW-1:0]));

    a_r3_bank_shift: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(bank_hit))
        |-> (bank_q == {$past(cpu_wdata[0]), $past(bank_q[BANK_W-1:1])}));

    a_r3_bank_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(bank_hit)) |-> $stable(bank_q));
endmodule

bind sound_bus_window sbw_checker #(
    .MB_AW  (MB_AW),
    .RAM_AW (RAM_AW),
    .BANK_W (MB_AW - 15)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .snd_wr    (snd_wr),
    .mb_req    (mb_req),
    .mb_ack    (mb_ack),
    .mb_we     (mb_we),
    .mb_addr   (mb_addr),
    .mb_wdata  (mb_wdata),
    .mb_mask   (mb_mask),
    .bank_q    (bank_q)
);

// File: tb/sound_bus_window_tb.sv
`timescale 1ns/1ps
module sound_bus_window_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic [12:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        snd_wr;
    logic [1:0]  snd_port;
    logic [7:0]  snd_wdata;
    logic [7:0]  snd_status = '0;
    logic        mb_req, mb_we;
    logic [23:0] mb_addr;
    logic [15:0] mb_wdata, mb_mask;
    logic [15:0] mb_rdata = '0;
    logic        mb_ack = 1'b0;

    int errors = 0, checks = 0, lat_cnt = 0;
    logic [8:0] bank_m = '0;

    logic        g_ram_we, g_snd_wr, g_mb_seen, g_mb_we;
    logic [12:0] g_ram_addr;
    logic [7:0]  g_ram_wdata, g_snd_wdata, g_rd;
    logic [1:0]  g_snd_port;
    logic [23:0] g_mb_addr;
    logic [15:0] g_mb_wdata, g_mb_mask;
    int          g_cycles;

    always #2 clk = ~clk;

    sound_bus_window u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .snd_wr(snd_wr),
        .snd_port(snd_port), .snd_wdata(snd_wdata), .snd_status(snd_status),
        .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .mb_mask(mb_mask), .mb_rdata(mb_rdata), .mb_ack(mb_ack)
    );

    function automatic logic [7:0] ram_f(logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    function automatic logic [15:0] mb_f(logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C69;
    endfunction

    assign ram_rdata = ram_f(ram_addr);

    always @(negedge clk) begin
        if (mb_ack) begin
            mb_ack  <= 1'b0;
            lat_cnt <= 0;
        end else if (mb_req) begin
            if (lat_cnt == 1) begin
                mb_ack   <= 1'b1;
                mb_rdata <= mb_f(mb_addr);
            end
            lat_cnt <= lat_cnt + 1;
        end
    end

    always @(posedge clk) if (mb_req) g_mb_seen <= 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        g_mb_seen = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        g_cycles = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            g_cycles++;
            #1;
        end
        g_rd = cpu_rdata;
        g_ram_we = ram_we; g_ram_addr = ram_addr; g_ram_wdata = ram_wdata;
        g_snd_wr = snd_wr; g_snd_port = snd_port; g_snd_wdata = snd_wdata;
        g_mb_addr = mb_addr; g_mb_we = mb_we; g_mb_wdata = mb_wdata; g_mb_mask = mb_mask;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a);
        logic [23:0] ea;
        logic [15:0] w;
        ea = a[15] ? {bank_m, a[14:1], 1'b0} : (24'hC00000 | {17'd0, a[6:1], 1'b0});
        xfer(1'b0, a, 8'h00);
        w = mb_f(ea);
        chk(a[15] ? "R6 window addr" : "R5 video addr", g_mb_addr, ea);
        chk("R7 read lane", g_rd, a[0] ? w[7:0] : w[15:8]);
        chk("R10 ready at ack", g_cycles, 2);
        chk("R10 read dir", g_mb_we, 0);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        logic [23:0] ea;
        ea = a[15] ? {bank_m, a[14:1], 1'b0} : (24'hC00000 | {17'd0, a[6:1], 1'b0});
        xfer(1'b1, a, d);
        chk(a[15] ? "R6 window waddr" : "R5 video waddr", g_mb_addr, ea);
        chk("R8 replicated data", g_mb_wdata, {d, d});
        chk("R8 lane mask", g_mb_mask, a[0] ? 16'h00FF : 16'hFF00);
        chk("R10 write ready at ack", g_cycles, 2);
        chk("R10 write dir", g_mb_we, 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R4 reset ready", cpu_ready, 0);
        chk("R4 reset mb_req", mb_req, 0);
        rst = 1'b0;

        // R4: first window access after reset sees bank zero
        bus_read(16'h8000);
        chk("R4 bank cleared", g_mb_addr[23:15], 9'd0);

        // R1: RAM sweep, reads and writes
        for (int a = 0; a < 16'h4000; a += 16'h0107) begin
            xfer(1'b0, a[15:0], 8'h00);
            chk("R1 ram read", g_rd, ram_f(a[12:0]));
            chk("R1 ram latency", g_cycles, 0);
        end
        for (int a = 3; a < 16'h4000; a += 16'h0A13) begin
            xfer(1'b1, a[15:0], a[7:0] ^ 8'h5C);
            chk("R1 ram we", g_ram_we, 1);
            chk("R1 ram addr", g_ram_addr, a[12:0]);
            chk("R1 ram wdata", g_ram_wdata, a[7:0] ^ 8'h5C);
            chk("R1 no bus", g_mb_seen, 0);
        end

        // R2: sound chip ports
        for (int a = 16'h4000; a < 16'h6000; a += 16'h0155) begin
            xfer(1'b1, a[15:0], a[9:2]);
            chk("R2 snd wr", g_snd_wr, 1);
            chk("R2 snd port", g_snd_port, a[1:0]);
            chk("R2 snd wdata", g_snd_wdata, a[9:2]);
            chk("R2 no ram we", g_ram_we, 0);
            snd_status = a[10:3] ^ 8'h96;
            xfer(1'b0, a[15:0], 8'h00);
            chk("R2 status read", g_rd, a[10:3] ^ 8'h96);
            chk("R2 latency", g_cycles, 0);
        end

        // R3: bank loading one bit per write, verified through the window
        for (int i = 0; i < 24; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 5);
            xfer(1'b1, 16'h6000 | 16'((i * 13) & 8'hFF), d);
            bank_m = {d[0], bank_m[8:1]};
            chk("R3 bank write latency", g_cycles, 0);
            if (i % 3 == 2) begin
                xfer(1'b0, 16'h6000 | 16'(i * 7), 8'h00);
                chk("R3 bank read open", g_rd, 8'hFF);
                bus_read(16'h8000 | 16'((i * 16'h0321) & 16'h7FFF));
                chk("R3 bank value", g_mb_addr[23:15], bank_m);
            end
        end

        // R9: unmapped holes
        for (int a = 16'h6100; a < 16'h7F00; a += 16'h00F7) begin
            xfer(1'b0, a[15:0], 8'h00);
            chk("R9 hole read", g_rd, 8'hFF);
            chk("R9 hole latency", g_cycles, 0);
            xfer(1'b1, a[15:0], 8'hA5 ^ a[7:0]);
            chk("R9 hole no ram", g_ram_we, 0);
            chk("R9 hole no snd", g_snd_wr, 0);
            chk("R9 hole no bus", g_mb_seen, 0);
        end
        bus_read(16'h9235);
        chk("R9 bank untouched", g_mb_addr[23:15], bank_m);

        // R5: video mirror reads and writes
        for (int a = 16'h7F00; a < 16'h8000; a += 16'h000B) begin
            bus_read(a[15:0]);
            bus_write(a[15:0], a[7:0] ^ 8'h3E);
        end

        // R6, R7, R8: window sweep across bank values
        for (int i = 0; i < 12; i++) begin
            xfer(1'b1, 16'h6000, 8'(i));
            bank_m = {i[0], bank_m[8:1]};
            bus_read(16'h8000 | 16'((i * 16'h0A57) & 16'h7FFF));
            bus_read(16'h8001 | 16'((i * 16'h1235) & 16'h7FFF));
            bus_write(16'h8000 | 16'((i * 16'h0777) & 16'h7FFE), 8'(i * 19));
            bus_write(16'hFFFF - 16'(i * 2), 8'(i * 23 + 1));
        end

        finish_run();
    end
endmodule